// File: doc/BRIEF.md
# Paged memory bank mapper

This block sits between a CPU with a 16-bit address bus and a larger physical ROM and RAM. The CPU space is cut into four 16 KB windows. The lowest window always shows ROM page 0 and the highest always shows RAM page 0. The two middle windows each show one page, chosen by a bank register: the second window shows a ROM page and the third shows a RAM page. For each memory request the block raises exactly one chip select and builds the physical address. The physical address is the page number placed above the 14 offset bits of the CPU address.

The CPU writes the two bank registers through an I/O write strobe with a one-bit register select. A written value of zero is replaced by one, so the window can never alias a fixed page. The block also flags accesses to the top 1 KB of the fixed RAM window, which holds the display buffer.

A separate combinational port translates a flat absolute RAM address into a RAM page number and the CPU window address at which that byte is seen. The flat space starts at 0C000h with RAM page 0 and runs through 2BFFFh with RAM page 7. Addresses outside that range are flagged invalid.

Top module: `bank_mapper`

## Requirements
- R1: A request with cpu_addr in 0000h-3FFFh asserts rom_cs, and rom_addr is {4'h0, cpu_addr[13:0]}.
- R2: A request with cpu_addr in 4000h-7FFFh asserts rom_cs, and rom_addr is {ROM bank register, cpu_addr[13:0]}.
- R3: A request with cpu_addr in 8000h-BFFFh asserts ram_cs, and ram_addr is {RAM bank register, cpu_addr[13:0]}.
- R4: A request with cpu_addr in C000h-FFFFh asserts ram_cs, and ram_addr is {3'h0, cpu_addr[13:0]}.
- R5: disp_hit is 1 exactly when mem_req is 1 and cpu_addr is FC00h or above.
- R6: When mem_req is 1 exactly one of rom_cs and ram_cs is 1. When mem_req is 0 both are 0.
- R7: After reset both bank registers hold 1.
- R8: When io_we is 1 at a rising clock edge, io_sel=0 loads io_wdata[3:0] into the ROM bank register and io_sel=1 loads io_wdata[2:0] into the RAM bank register. For the RAM bank, io_wdata[3] is ignored. The new value is used by every access after that edge.
- R9: A write whose stored field would be zero loads 1 instead, for either register.
- R10: An absolute address in 0C000h-0FFFFh gives xl_page 0, xl_win equal to abs_addr[15:0], and xl_invalid 0.
- R11: An absolute address in 10000h-2BFFFh gives xl_page equal to abs_addr[17:14] minus 3, xl_win equal to 8000h plus abs_addr[13:0], and xl_invalid 0.
- R12: An absolute address below 0C000h or above 2BFFFh gives xl_invalid 1 with xl_page 0 and xl_win 0.
- R13: With io_we at 0, neither bank register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_we | input | 1 | I/O write strobe for the bank registers |
| io_sel | input | 1 | Register select: 0 = ROM bank, 1 = RAM bank |
| io_wdata | input | 4 | Bank value to write |
| mem_req | input | 1 | CPU memory request |
| cpu_addr | input | 16 | CPU address |
| rom_cs | output | 1 | ROM chip select |
| ram_cs | output | 1 | RAM chip select |
| rom_addr | output | 18 | Physical ROM address |
| ram_addr | output | 17 | Physical RAM address |
| disp_hit | output | 1 | Access falls in the display buffer |
| abs_addr | input | 18 | Flat absolute RAM address to translate |
| xl_page | output | 3 | Translated RAM page |
| xl_win | output | 16 | CPU window address for the absolute address |
| xl_invalid | output | 1 | Absolute address is outside the RAM range |

## Verification
The hardest case to reach is a bank write of zero followed at once by an access to that bank's window. Only that sequence exposes the zero-to-one replacement, and random data rarely produces it. The same is true of a RAM write with bit 3 set whose low bits are zero. Directed writes of 0h and 8h to each register cover these, each followed in the next cycle by an access to the window. The random traffic also sends absolute addresses across the whole 18-bit range, and directed values sit on each edge of the valid span.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int OFS_W       = 14;
  localparam int CPU_AW      = 16;
  localparam int ROM_PG_W    = 4;
  localparam int RAM_PG_W    = 3;
  localparam int ABS_AW      = 18;
  localparam int ABS_BASE_PG = 3;

  typedef enum logic [1:0] {
    WIN_ROM_FIX  = 2'd0,
    WIN_ROM_BANK = 2'd1,
    WIN_RAM_BANK = 2'd2,
    WIN_RAM_FIX  = 2'd3
  } win_e;

  // Map a raw bank field to a legal page: zero would alias the fixed page.
  function automatic logic [7:0] legal_bank(input logic [7:0] raw);
    return (raw == 8'd0) ? 8'd1 : raw;
  endfunction
endpackage

// File: rtl/bank_regs.sv
`timescale 1ns/1ps
module bank_regs #(
  parameter int ROM_W = bank_mapper_pkg::ROM_PG_W,
  parameter int RAM_W = bank_mapper_pkg::RAM_PG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_we,
  input  logic             io_sel,
  input  logic [ROM_W-1:0] io_wdata,
  output logic [ROM_W-1:0] rom_bank,
  output logic [RAM_W-1:0] ram_bank
);
  import bank_mapper_pkg::*;

  logic [ROM_W-1:0] rom_next;
  logic [RAM_W-1:0] ram_next;
  logic             rom_wr;
  logic             ram_wr;

  assign rom_wr   = io_we && !io_sel;
  assign ram_wr   = io_we && io_sel;
  assign rom_next = ROM_W'(legal_bank(8'(io_wdata)));
  assign ram_next = RAM_W'(legal_bank(8'(io_wdata[RAM_W-1:0])));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_bank <= ROM_W'(1);
      ram_bank <= RAM_W'(1);
    end else begin
      if (rom_wr) rom_bank <= rom_next;
      if (ram_wr) ram_bank <= ram_next;
    end
  end
endmodule

// File: rtl/cpu_decode.sv
`timescale 1ns/1ps
module cpu_decode #(
  parameter int          CPU_AW    = bank_mapper_pkg::CPU_AW,
  parameter int          OFS_W     = bank_mapper_pkg::OFS_W,
  parameter int          ROM_W     = bank_mapper_pkg::ROM_PG_W,
  parameter int          RAM_W     = bank_mapper_pkg::RAM_PG_W,
  parameter logic [15:0] DISP_BASE = 16'hFC00
) (
  input  logic                   mem_req,
  input  logic [CPU_AW-1:0]      cpu_addr,
  input  logic [ROM_W-1:0]       rom_bank,
  input  logic [RAM_W-1:0]       ram_bank,
  output logic                   rom_cs,
  output logic                   ram_cs,
  output logic [ROM_W+OFS_W-1:0] rom_addr,
  output logic [RAM_W+OFS_W-1:0] ram_addr,
  output logic                   disp_hit,
  output bank_mapper_pkg::win_e  win
);
  import bank_mapper_pkg::*;

  logic [OFS_W-1:0] ofs;
  logic [ROM_W-1:0] rom_pg;
  logic [RAM_W-1:0] ram_pg;

  assign ofs = cpu_addr[OFS_W-1:0];
  assign win = win_e'(cpu_addr[CPU_AW-1 -: 2]);

  always_comb begin
    rom_pg = '0;
    ram_pg = '0;
    unique case (win)
      WIN_ROM_FIX:  rom_pg = '0;
      WIN_ROM_BANK: rom_pg = rom_bank;
      WIN_RAM_BANK: ram_pg = ram_bank;
      WIN_RAM_FIX:  ram_pg = '0;
    endcase
  end

  assign rom_cs   = mem_req && (win == WIN_ROM_FIX || win == WIN_ROM_BANK);
  assign ram_cs   = mem_req && (win == WIN_RAM_BANK || win == WIN_RAM_FIX);
  assign rom_addr = {rom_pg, ofs};
  assign ram_addr = {ram_pg, ofs};
  assign disp_hit = mem_req && (cpu_addr >= CPU_AW'(DISP_BASE));
endmodule

// File: rtl/abs_xlate.sv
`timescale 1ns/1ps
module abs_xlate #(
  parameter int ABS_AW  = bank_mapper_pkg::ABS_AW,
  parameter int OFS_W   = bank_mapper_pkg::OFS_W,
  parameter int RAM_W   = bank_mapper_pkg::RAM_PG_W,
  parameter int BASE_PG = bank_mapper_pkg::ABS_BASE_PG
) (
  input  logic [ABS_AW-1:0] abs_addr,
  output logic [RAM_W-1:0]  xl_page,
  output logic [15:0]       xl_win,
  output logic              xl_invalid
);
  localparam int              IDX_W = ABS_AW - OFS_W;
  localparam logic [IDX_W-1:0] FIRST = IDX_W'(BASE_PG);
  localparam logic [IDX_W-1:0] LAST  = IDX_W'(BASE_PG + (1 << RAM_W) - 1);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] rel;
  logic [OFS_W-1:0] ofs;
  logic             in_range;

  assign idx      = abs_addr[ABS_AW-1:OFS_W];
  assign ofs      = abs_addr[OFS_W-1:0];
  assign rel      = idx - FIRST;
  assign in_range = (idx >= FIRST) && (idx <= LAST);

  always_comb begin
    xl_invalid = !in_range;
    xl_page    = '0;
    xl_win     = '0;
    if (in_range) begin
      xl_page = rel[RAM_W-1:0];
      xl_win  = (rel == '0) ? {2'b11, ofs} : {2'b10, ofs};
    end
  end
endmodule

// File: rtl/bank_mapper.sv
`timescale 1ns/1ps
module bank_mapper #(
  parameter int OFS_W    = bank_mapper_pkg::OFS_W,
  parameter int CPU_AW   = bank_mapper_pkg::CPU_AW,
  parameter int ROM_PG_W = bank_mapper_pkg::ROM_PG_W,
  parameter int RAM_PG_W = bank_mapper_pkg::RAM_PG_W,
  parameter int ABS_AW   = bank_mapper_pkg::ABS_AW,
  localparam int ROM_AW  = ROM_PG_W + OFS_W,
  localparam int RAM_AW  = RAM_PG_W + OFS_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                io_we,
  input  logic                io_sel,
  input  logic [ROM_PG_W-1:0] io_wdata,
  input  logic                mem_req,
  input  logic [CPU_AW-1:0]   cpu_addr,
  output logic                rom_cs,
  output logic                ram_cs,
  output logic [ROM_AW-1:0]   rom_addr,
  output logic [RAM_AW-1:0]   ram_addr,
  output logic                disp_hit,
  input  logic [ABS_AW-1:0]   abs_addr,
  output logic [RAM_PG_W-1:0] xl_page,
  output logic [15:0]         xl_win,
  output logic                xl_invalid
);
  logic [ROM_PG_W-1:0]   rom_bank;
  logic [RAM_PG_W-1:0]   ram_bank;
  bank_mapper_pkg::win_e win;

  bank_regs #(.ROM_W(ROM_PG_W), .RAM_W(RAM_PG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_sel(io_sel),
    .io_wdata(io_wdata), .rom_bank(rom_bank), .ram_bank(ram_bank)
  );

  cpu_decode #(.CPU_AW(CPU_AW), .OFS_W(OFS_W), .ROM_W(ROM_PG_W), .RAM_W(RAM_PG_W)) u_dec (
    .mem_req(mem_req), .cpu_addr(cpu_addr), .rom_bank(rom_bank), .ram_bank(ram_bank),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .rom_addr(rom_addr), .ram_addr(ram_addr),
    .disp_hit(disp_hit), .win(win)
  );

  abs_xlate #(.ABS_AW(ABS_AW), .OFS_W(OFS_W), .RAM_W(RAM_PG_W)) u_xl (
    .abs_addr(abs_addr), .xl_page(xl_page), .xl_win(xl_win), .xl_invalid(xl_invalid)
  );
endmodule

// File: rtl/bank_mapper_chk.sv
`timescale 1ns/1ps
module bank_mapper_chk #(
  parameter int OFS_W = 14, CPU_AW = 16, ROM_PG_W = 4, RAM_PG_W = 3, ABS_AW = 18
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        io_we,
  input logic                        io_sel,
  input logic [ROM_PG_W-1:0]         io_wdata,
  input logic                        mem_req,
  input logic [CPU_AW-1:0]           cpu_addr,
  input logic                        rom_cs,
  input logic                        ram_cs,
  input logic [ROM_PG_W+OFS_W-1:0]   rom_addr,
  input logic [RAM_PG_W+OFS_W-1:0]   ram_addr,
  input logic                        disp_hit,
  input logic [ABS_AW-1:0]           abs_addr,
  input logic [RAM_PG_W-1:0]         xl_page,
  input logic [15:0]                 xl_win,
  input logic                        xl_invalid,
  input logic [ROM_PG_W-1:0]         rom_bank,
  input logic [RAM_PG_W-1:0]         ram_bank
);
  logic [1:0] top2;
  assign top2 = cpu_addr[CPU_AW-1 -: 2];

  // R6
  cs_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $countones({rom_cs, ram_cs}) == 1);
  // R6
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> (!rom_cs && !ram_cs));
  // R1
  rom_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && top2 == 2'b00) |-> (rom_cs && rom_addr[ROM_PG_W+OFS_W-1:OFS_W] == '0));
  // R4
  ram_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && top2 == 2'b11) |-> (ram_cs && ram_addr[RAM_PG_W+OFS_W-1:OFS_W] == '0));
  // R5
  disp_in_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_hit |-> (ram_cs && top2 == 2'b11));
  // R9
  bank_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_bank != '0) && (ram_bank != '0));
  // R13
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_we |=> ($stable(rom_bank) && $stable(ram_bank)));
  // R8
  ram_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_sel && io_wdata[RAM_PG_W-1:0] != '0) |=>
      (!(mem_req && top2 == 2'b10) ||
       ram_addr[RAM_PG_W+OFS_W-1:OFS_W] == $past(io_wdata[RAM_PG_W-1:0])));
  // R12
  xl_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_invalid |-> (xl_page == '0 && xl_win == '0));
  // R10
  xl_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xl_invalid && xl_page == '0) |-> xl_win == abs_addr[15:0]);
  // R11
  xl_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xl_invalid && xl_page != '0) |-> xl_win[15:14] == 2'b10);
endmodule

bind bank_mapper bank_mapper_chk #(
  .OFS_W(OFS_W), .CPU_AW(CPU_AW), .ROM_PG_W(ROM_PG_W), .RAM_PG_W(RAM_PG_W), .ABS_AW(ABS_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_sel(io_sel), .io_wdata(io_wdata),
  .mem_req(mem_req), .cpu_addr(cpu_addr), .rom_cs(rom_cs), .ram_cs(ram_cs),
  .rom_addr(rom_addr), .ram_addr(ram_addr), .disp_hit(disp_hit), .abs_addr(abs_addr),
  .xl_page(xl_page), .xl_win(xl_win), .xl_invalid(xl_invalid),
  .rom_bank(rom_bank), .ram_bank(ram_bank)
);

// File: tb/test_bank_mapper.sv
`timescale 1ns/1ps
module test_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_we = 1'b0, io_sel = 1'b0;
  logic [3:0]  io_wdata = '0;
  logic        mem_req = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [17:0] abs_addr = '0;
  logic        rom_cs, ram_cs, disp_hit, xl_invalid;
  logic [17:0] rom_addr;
  logic [16:0] ram_addr;
  logic [2:0]  xl_page;
  logic [15:0] xl_win;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [3:0] m_rom = 4'd1;
  logic [2:0] m_ram = 3'd1;

  always #5 clk = ~clk;

  bank_mapper i_bank_mapper (
    .clk(clk), .rst_n(rst_n), .io_we(io_we), .io_sel(io_sel), .io_wdata(io_wdata),
    .mem_req(mem_req), .cpu_addr(cpu_addr), .rom_cs(rom_cs), .ram_cs(ram_cs),
    .rom_addr(rom_addr), .ram_addr(ram_addr), .disp_hit(disp_hit),
    .abs_addr(abs_addr), .xl_page(xl_page), .xl_win(xl_win), .xl_invalid(xl_invalid)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected CPU-side results, written from the requirements.
  task automatic check_cpu();
    logic [1:0] w = cpu_addr[15:14];
    string tag;
    if (!mem_req) begin
      check("R6", "idle cs", {rom_cs, ram_cs}, 0);
      check("R5", "idle disp", disp_hit, 0);
      return;
    end
    tag = (w == 0) ? "R1" : (w == 1) ? "R2" : (w == 2) ? "R3" : "R4";
    check("R6", "cs pair", {rom_cs, ram_cs}, (w < 2) ? 2'b10 : 2'b01);
    if (w == 0) check(tag, "rom_addr", rom_addr, {4'h0, cpu_addr[13:0]});
    if (w == 1) check(tag, "rom_addr", rom_addr, {m_rom, cpu_addr[13:0]});
    if (w == 2) check(tag, "ram_addr", ram_addr, {m_ram, cpu_addr[13:0]});
    if (w == 3) check(tag, "ram_addr", ram_addr, {3'h0, cpu_addr[13:0]});
    check("R5", "disp", disp_hit, cpu_addr >= 16'hFC00);
  endtask

  task automatic check_xl();
    int a = int'(abs_addr);
    if (a < 'h0C000 || a > 'h2BFFF) begin
      check("R12", "invalid", {xl_invalid, xl_page, xl_win}, {1'b1, 3'd0, 16'd0});
    end else if (a < 'h10000) begin
      check("R10", "page0", {xl_invalid, xl_page, xl_win}, {1'b0, 3'd0, abs_addr[15:0]});
    end else begin
      check("R11", "paged", {xl_invalid, xl_page, xl_win},
            {1'b0, 3'((a / 'h4000) - 3), 16'h8000 + 16'(a % 'h4000)});
    end
  endtask

  // Drive one cycle at the falling edge, check combinational outputs, then clock.
  task automatic step(input logic we, input logic sel, input logic [3:0] d,
                      input logic req, input logic [15:0] a, input logic [17:0] ab);
    @(negedge clk);
    io_we = we; io_sel = sel; io_wdata = d;
    mem_req = req; cpu_addr = a; abs_addr = ab;
    #2;
    check_cpu();
    check_xl();
    @(posedge clk);
    if (we) begin
      if (!sel) m_rom = (d == 0) ? 4'd1 : d;
      else      m_ram = (d[2:0] == 0) ? 3'd1 : d[2:0];
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R7: reset banks are 1 in both windows
    step(0, 0, 0, 1, 16'h4123, 18'h0C000);
    check("R7", "rom after reset", rom_addr[17:14], 1);
    step(0, 0, 0, 1, 16'h8456, 18'h0BFFF);
    check("R7", "ram after reset", ram_addr[16:14], 1);
    // R8 writes, R9 zero remap, upper bit ignored on RAM
    step(1, 0, 4'hF, 0, 16'h0000, 18'h0FFFF);
    step(0, 0, 0, 1, 16'h7FFF, 18'h10000);
    step(1, 1, 4'hD, 1, 16'hC000, 18'h2BFFF);   // RAM bank -> 5
    step(0, 0, 0, 1, 16'hBFFF, 18'h2C000);
    step(1, 1, 4'h8, 1, 16'hFBFF, 18'h3FFFF);   // R9: low bits zero -> 1
    step(0, 0, 0, 1, 16'h8000, 18'h00000);
    check("R9", "ram zero write", ram_addr[16:14], 1);
    step(1, 0, 4'h0, 1, 16'hFC00, 18'h13FFF);   // R9: ROM zero -> 1
    step(0, 0, 0, 1, 16'h4000, 18'h14000);
    check("R9", "rom zero write", rom_addr[17:14], 1);
    // R13: no strobe, data ignored
    step(0, 1, 4'h6, 1, 16'h3FFF, 18'h28000);
    step(0, 0, 4'h9, 1, 16'h8001, 18'h27FFF);
    check("R13", "ram hold", ram_addr[16:14], 1);
    step(0, 0, 0, 1, 16'h4001, 18'h20000);
    check("R13", "rom hold", rom_addr[17:14], 1);
    step(0, 0, 0, 0, 16'hFFFF, 18'h1C000);
    for (int i = 0; i < 3000; i++) begin
      logic we = ($urandom % 6) == 0;
      step(we, 1'($urandom), 4'($urandom), ($urandom % 4) != 0,
           16'($urandom), 18'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule